// File: doc/BRIEF.md
# Conditional Branch Resolver

This block settles the outcome of a conditional branch in a small 8-bit processor core. When the sequencer presents a branch, it supplies a 4-bit condition selector, the processor status byte and the address of the branch opcode. The resolver reads the branch destination byte from the location that follows the opcode, through a one-request, one-response memory read port.

It then evaluates the selected condition against the captured flags. It returns a one-cycle completion strobe with the decision and the program counter to install. The core adds one to the program counter at the end of every instruction. For that reason, a taken branch installs the destination minus one, and an untaken branch installs the operand address. Both wrap modulo 256.

Status flag positions are fixed: negative at bit 0, zero at bit 1, overflow at bit 2 and carry at bit 3. The remaining status bits, including the interrupt-enable bit at bit 7, do not take part in any decision.

Top module: `br_resolve_unit`

## Requirements
- R1: After reset, `done_o`, `taken_o`, `illegal_o` and `rd_req_o` are 0 and `next_pc_o` is 0x00.
- R2: A `start_i` accepted while idle raises `rd_req_o` in the next cycle for exactly one cycle, with `rd_addr_o` = `pc_i` + 1 modulo 256.
- R3: `done_o` is high for exactly one cycle: the cycle after the one in which `rd_valid_i` is high while a read is outstanding.
- R4: On a taken branch, `next_pc_o` = `rd_data_i` − 1 modulo 256, where `rd_data_i` is the byte returned by the read, and `taken_o` = 1.
- R5: On an untaken branch, `next_pc_o` = `pc_i` + 1 modulo 256 and `taken_o` = 0.
- R6: The flag codes decide as follows: 0 takes on Z, 1 on !Z, 2 on C, 3 on !C, 4 on N, 5 on !N, 6 on V, 7 on !V.
- R7: Code 8 takes on C·!Z. Code 9 takes on !C + Z.
- R8: Code 10 takes on V·N + !V·!Z·!N + Z. Code 11 takes on !V·N + V·!Z·!N. Code 12 takes on V·N + !V·!Z·!N. Code 13 takes on Z + !V·N + V·!Z·!N.
- R9: Code 14 always takes. Code 15 never takes.
- R10: `illegal_o` never asserts, because every one of the 16 codes is defined.
- R11: A `start_i` that arrives while a resolution is in progress has no effect: it issues no read and does not change the result.
- R12: The resolver waits any number of cycles for `rd_valid_i`, holding `rd_addr_o` steady. Status bits 7 to 4 have no effect on the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin resolving a branch |
| cond_i | input | 4 | Condition selector |
| status_i | input | 8 | Processor status byte |
| pc_i | input | 8 | Address of the branch opcode |
| rd_req_o | output | 1 | Operand read request, one cycle |
| rd_addr_o | output | 8 | Operand read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 8 | Branch destination byte |
| done_o | output | 1 | Result strobe |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 8 | Program counter to install |
| illegal_o | output | 1 | Undefined condition selector |

## Verification
The hardest case to reach from the ports is a start request that arrives while a read is still outstanding. The bench gets there by holding `start_i` high, with a different program counter, throughout the request and wait cycles. It then confirms that no second read follows and that the result belongs to the first branch. The signed conditions are covered by sweeping all 16 codes against all 16 flag patterns, with varying upper status bits. Address wrap is covered by a branch at 0xFF and a destination of 0x00. Extra response latency is injected to confirm that the result waits for `rd_valid_i`.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int unsigned CW = 4;
  localparam int unsigned FLAG_N = 0;
  localparam int unsigned FLAG_Z = 1;
  localparam int unsigned FLAG_V = 2;
  localparam int unsigned FLAG_C = 3;

  typedef enum logic [CW-1:0] {
    C_EQ = 4'd0,  C_NE = 4'd1,  C_HS = 4'd2,  C_LO = 4'd3,
    C_MI = 4'd4,  C_PL = 4'd5,  C_VS = 4'd6,  C_VC = 4'd7,
    C_HI = 4'd8,  C_LS = 4'd9,  C_GE = 4'd10, C_LT = 4'd11,
    C_GT = 4'd12, C_LE = 4'd13, C_AL = 4'd14, C_NV = 4'd15
  } cond_e;

  typedef enum logic [1:0] {F_IDLE, F_ISSUE, F_WAIT} fetch_st_e;

  typedef struct packed {
    logic c;
    logic v;
    logic z;
    logic n;
  } flags_t;
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
(
  input  logic [CW-1:0] cond_i,
  input  flags_t        flags_i,
  output logic          take_o,
  output logic          illegal_o
);
  logic c, v, z, n, lt_term, gt_term;
  assign c = flags_i.c;
  assign v = flags_i.v;
  assign z = flags_i.z;
  assign n = flags_i.n;
  // signed helper terms; zero handled separately per condition
  assign lt_term = (!v && n) || (v && !z && !n);
  assign gt_term = (v && n) || (!v && !z && !n);

  always_comb begin
    take_o    = 1'b0;
    illegal_o = 1'b0;
    case (cond_i)
      C_EQ: take_o = z;
      C_NE: take_o = !z;
      C_HS: take_o = c;
      C_LO: take_o = !c;
      C_MI: take_o = n;
      C_PL: take_o = !n;
      C_VS: take_o = v;
      C_VC: take_o = !v;
      C_HI: take_o = c && !z;
      C_LS: take_o = !c || z;
      C_GE: take_o = gt_term || z;
      C_LT: take_o = lt_term;
      C_GT: take_o = gt_term;
      C_LE: take_o = z || lt_term;
      C_AL: take_o = 1'b1;
      C_NV: take_o = 1'b0;
      default: illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/br_operand_fetch.sv
module br_operand_fetch
  import br_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] pc_i,
  input  logic         rd_valid_i,
  output logic         rd_req_o,
  output logic [W-1:0] rd_addr_o,
  output logic         accept_o,
  output logic         got_o,
  output logic         busy_o,
  output logic         waiting_o
);
  fetch_st_e    st_q;
  logic [W-1:0] addr_q;

  assign accept_o  = (st_q == F_IDLE) && start_i;
  assign got_o     = (st_q == F_WAIT) && rd_valid_i;
  assign busy_o    = (st_q != F_IDLE);
  assign waiting_o = (st_q == F_WAIT);
  assign rd_req_o  = (st_q == F_ISSUE);
  assign rd_addr_o = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= F_IDLE;
      addr_q <= '0;
    end else begin
      case (st_q)
        F_IDLE: if (start_i) begin
          addr_q <= pc_i + W'(1);
          st_q   <= F_ISSUE;
        end
        F_ISSUE: st_q <= F_WAIT;
        F_WAIT:  if (rd_valid_i) st_q <= F_IDLE;
        default: st_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/br_pc_calc.sv
module br_pc_calc #(
  parameter int unsigned W = 8
) (
  input  logic         take_i,
  input  logic [W-1:0] target_i,
  input  logic [W-1:0] opnd_addr_i,
  output logic [W-1:0] next_pc_o
);
  // taken: preload one below the destination for the common post-increment
  assign next_pc_o = take_i ? (target_i - W'(1)) : opnd_addr_i;
endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit
  import br_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [CW-1:0] cond_i,
  input  logic [SW-1:0] status_i,
  input  logic [W-1:0]  pc_i,
  output logic          rd_req_o,
  output logic [W-1:0]  rd_addr_o,
  input  logic          rd_valid_i,
  input  logic [W-1:0]  rd_data_i,
  output logic          done_o,
  output logic          taken_o,
  output logic [W-1:0]  next_pc_o,
  output logic          illegal_o
);
  localparam int unsigned FLAG_TOP = FLAG_C;

  logic          accept, got, busy, waiting;
  logic          take, illegal;
  logic [CW-1:0] cond_q;
  flags_t        flags_q;
  logic [W-1:0]  calc_pc;
  logic          unused_status;

  assign unused_status = ^status_i[SW-1:FLAG_TOP+1];

  br_operand_fetch #(.W(W)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .pc_i      (pc_i),
    .rd_valid_i(rd_valid_i),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .accept_o  (accept),
    .got_o     (got),
    .busy_o    (busy),
    .waiting_o (waiting)
  );

  br_cond_eval u_eval (
    .cond_i   (cond_q),
    .flags_i  (flags_q),
    .take_o   (take),
    .illegal_o(illegal)
  );

  br_pc_calc #(.W(W)) u_pc (
    .take_i     (take),
    .target_i   (rd_data_i),
    .opnd_addr_i(rd_addr_o),
    .next_pc_o  (calc_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q    <= '0;
      flags_q   <= '0;
      done_o    <= 1'b0;
      taken_o   <= 1'b0;
      next_pc_o <= '0;
      illegal_o <= 1'b0;
    end else begin
      done_o <= got;
      if (accept) begin
        cond_q  <= cond_i;
        flags_q <= '{c: status_i[FLAG_C], v: status_i[FLAG_V],
                     z: status_i[FLAG_Z], n: status_i[FLAG_N]};
      end
      if (got) begin
        taken_o   <= take;
        next_pc_o <= calc_pc;
        illegal_o <= illegal;
      end
    end
  end
endmodule

// File: rtl/br_resolve_unit_chk.sv
module br_resolve_unit_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic         rd_req_o,
  input logic [W-1:0] rd_addr_o,
  input logic         rd_valid_i,
  input logic [W-1:0] rd_data_i,
  input logic         done_o,
  input logic         taken_o,
  input logic [W-1:0] next_pc_o,
  input logic         illegal_o,
  input logic         busy,
  input logic         waiting
);
  assert_req_single_R2: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |=> !rd_req_o);
  assert_req_follows_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_i) |=> rd_req_o);
  assert_done_after_data_R3: assert property (@(posedge clk) disable iff (rst)
    (waiting && rd_valid_i) |=> done_o);
  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_taken_pc_R4: assert property (@(posedge clk) disable iff (rst)
    (done_o && taken_o) |-> (next_pc_o == W'($past(rd_data_i) - W'(1))));
  assert_untaken_pc_R5: assert property (@(posedge clk) disable iff (rst)
    (done_o && !taken_o) |-> (next_pc_o == $past(rd_addr_o)));
  assert_no_illegal_R10: assert property (@(posedge clk) disable iff (rst)
    !illegal_o);
  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && start_i) |=> !rd_req_o);
  assert_addr_held_R12: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(rst)) |-> $stable(rd_addr_o));
endmodule

bind br_resolve_unit br_resolve_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .rd_req_o  (rd_req_o),
  .rd_addr_o (rd_addr_o),
  .rd_valid_i(rd_valid_i),
  .rd_data_i (rd_data_i),
  .done_o    (done_o),
  .taken_o   (taken_o),
  .next_pc_o (next_pc_o),
  .illegal_o (illegal_o),
  .busy      (busy),
  .waiting   (waiting)
);

// File: tb/tb_br_resolve_unit.sv
`timescale 1ns/1ps
module tb_br_resolve_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [3:0] cond_i = '0;
  logic [7:0] status_i = '0;
  logic [7:0] pc_i = '0;
  logic       rd_valid_i = 1'b0;
  logic [7:0] rd_data_i = '0;
  logic       rd_req_o, done_o, taken_o, illegal_o;
  logic [7:0] rd_addr_o, next_pc_o;
  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  br_resolve_unit dut (
    .clk(clk), .rst(rst), .start_i(start_i), .cond_i(cond_i),
    .status_i(status_i), .pc_i(pc_i), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .done_o(done_o), .taken_o(taken_o), .next_pc_o(next_pc_o),
    .illegal_o(illegal_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit ref_take(input logic [3:0] cd, input logic [7:0] st);
    bit c, v, z, n;
    c = st[3]; v = st[2]; z = st[1]; n = st[0];
    case (cd)
      4'd0: return z;
      4'd1: return !z;
      4'd2: return c;
      4'd3: return !c;
      4'd4: return n;
      4'd5: return !n;
      4'd6: return v;
      4'd7: return !v;
      4'd8: return c && !z;
      4'd9: return !c || z;
      4'd10: return (v && n) || (!v && !z && !n) || z;
      4'd11: return (!v && n) || (v && !z && !n);
      4'd12: return (v && n) || (!v && !z && !n);
      4'd13: return z || (!v && n) || (v && !z && !n);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] cd);
    if (cd < 4'd8) return "R6";
    if (cd < 4'd10) return "R7";
    if (cd < 4'd14) return "R8";
    return "R9";
  endfunction

  // One branch resolution; extra = added response latency; junk = hold start busy
  task automatic resolve(input logic [3:0] cd, input logic [7:0] st,
                         input logic [7:0] pc, input logic [7:0] tgt,
                         input int extra, input bit junk);
    bit exp_t;
    logic [7:0] exp_pc;
    exp_t  = ref_take(cd, st);
    exp_pc = exp_t ? 8'(tgt - 8'd1) : 8'(pc + 8'd1);
    @(negedge clk);
    cond_i = cd; status_i = st; pc_i = pc; start_i = 1'b1;
    @(negedge clk);
    chk(rd_req_o === 1'b1, "R2", rd_req_o, 1);
    chk(rd_addr_o === 8'(pc + 8'd1), "R2", rd_addr_o, 8'(pc + 8'd1));
    if (junk) begin
      pc_i = pc ^ 8'h3C; cond_i = ~cd; status_i = ~st;
    end else start_i = 1'b0;
    @(negedge clk);
    chk(rd_req_o === 1'b0, "R2", rd_req_o, 0);
    for (int k = 0; k < extra; k++) begin
      chk(done_o === 1'b0, "R12", done_o, 0);
      chk(rd_addr_o === 8'(pc + 8'd1), "R12", rd_addr_o, 8'(pc + 8'd1));
      chk(rd_req_o === 1'b0, junk ? "R11" : "R12", rd_req_o, 0);
      @(negedge clk);
    end
    chk(done_o === 1'b0, "R3", done_o, 0);
    rd_valid_i = 1'b1; rd_data_i = tgt;
    @(negedge clk);
    rd_valid_i = 1'b0; rd_data_i = ~tgt;
    chk(done_o === 1'b1, "R3", done_o, 1);
    chk(taken_o === exp_t, req_of(cd), taken_o, exp_t);
    chk(next_pc_o === exp_pc, exp_t ? "R4" : "R5", next_pc_o, exp_pc);
    chk(illegal_o === 1'b0, "R10", illegal_o, 0);
    start_i = 1'b0;
    @(negedge clk);
    chk(done_o === 1'b0, "R3", done_o, 0);
    chk(rd_req_o === 1'b0, junk ? "R11" : "R2", rd_req_o, 0);
    chk(next_pc_o === exp_pc, junk ? "R11" : "R4", next_pc_o, exp_pc);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(done_o === 1'b0, "R1", done_o, 0);
    chk(taken_o === 1'b0, "R1", taken_o, 0);
    chk(illegal_o === 1'b0, "R1", illegal_o, 0);
    chk(rd_req_o === 1'b0, "R1", rd_req_o, 0);
    chk(next_pc_o === 8'h00, "R1", next_pc_o, 0);
  endtask

  // R6 R7 R8 R9 R12: every code against every flag pattern, upper bits varied
  task automatic t_sweep();
    for (int cd = 0; cd < 16; cd++)
      for (int f = 0; f < 16; f++)
        resolve(4'(cd), {4'((cd * 5 + f * 3) & 15), 4'(f)}, 8'(cd * 16 + f),
                8'((f * 29 + cd * 7 + 3) & 255), 0, 1'b0);
  endtask

  // R4 R5 R2: wraparound of operand address and of destination minus one
  task automatic t_wrap();
    resolve(4'd15, 8'h00, 8'hFF, 8'h42, 0, 1'b0);
    resolve(4'd14, 8'h00, 8'h10, 8'h00, 0, 1'b0);
    resolve(4'd14, 8'h00, 8'hFF, 8'h00, 0, 1'b0);
  endtask

  // R12: slow memory responses
  task automatic t_latency();
    resolve(4'd10, 8'h82, 8'h20, 8'h90, 3, 1'b0);
    resolve(4'd11, 8'h05, 8'h33, 8'h07, 5, 1'b0);
  endtask

  // R11: start held high throughout an outstanding read
  task automatic t_busy_start();
    resolve(4'd0, 8'h02, 8'h50, 8'hA0, 2, 1'b1);
    resolve(4'd13, 8'h04, 8'h60, 8'h11, 0, 1'b1);
  endtask

  initial begin
    #(200000 * 20);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset();
    t_sweep();
    t_wrap();
    t_latency();
    t_busy_start();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule